// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a 32-bit in-order processor core split into five stages: fetch, decode, execute, memory access and write-back. It runs a small load/store subset: register-to-register add, subtract, AND and OR, word load, word store and a branch taken when two registers are equal. The instruction and data stores are small arrays inside the block. The instruction store is filled through a load port while the core is held in reset.

Control is decoded once, in the decode stage. The resulting bits are split into three groups by the stage that uses them: execute, memory and write-back. Each group travels down the stage registers next to the data and the destination register number, and is dropped after the stage that uses it. The PC and all four stage registers load on every clock edge. There is no stall, forwarding or flush logic, so test programs must keep dependent instructions at least three slots apart.

Outputs show the fetch address, every register-file write and every data-store write. A surrounding bench or debug environment can follow execution through them.

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted the PC is set to RESET_PC and every stage register holds a no-op. In the first cycle after reset, fetch_pc equals RESET_PC and both wb_we and dmem_we are low.
- R2: When no branch is taken, fetch_pc rises by 4 on every clock edge.
- R3: Instruction fields are decoded as follows:
  - opcode is in [31:26]: 0x00 register form, 0x23 load word, 0x2B store word, 0x04 branch-if-equal;
  - the source registers are in [25:21] and [20:16], and the register-form destination is in [15:11];
  - the sign-extended immediate is in [15:0];
  - the register-form function code is in [5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR.

  At most one of load, store and branch is active in the memory stage.
- R4: A register-form instruction writes the ALU result of its two source registers into the register at [15:11].
- R5: A load word writes the data word at (source [25:21] + sign-extended immediate) into the register at [20:16]. The data store is word-indexed by address bits [log2(DMEM_WORDS)+1:2].
- R6: A store word writes register [20:16] to the data store at (source [25:21] + sign-extended immediate). During its memory-stage cycle it shows dmem_we high with the full 32-bit address on dmem_addr and the data on dmem_wdata. It writes no register.
- R7: A branch-if-equal whose two registers match loads the PC with (its address + 4) + (sign-extended immediate shifted left by 2). This happens at the end of its memory-stage cycle, and the three instructions that follow it still execute. A branch whose registers differ leaves the fetch sequence unchanged. A branch writes no register.
- R8: An instruction fetched in cycle n shows its register write on wb_we, wb_dest and wb_data in cycle n+4. Cycle 1 is the first cycle after reset. After that, one instruction retires per cycle.
- R9: A register written in the write-back stage is read with its new value by the instruction being decoded in that same cycle, which is the instruction three slots later.
- R10: Register 0 always reads as zero, and an instruction targeting it raises no wb_we.
- R11: An opcode outside the supported set acts as a no-op. It writes no register, writes no data word and does not change the PC.
- R12: After reset, register i (i > 0) holds i + RF_INIT_BASE and every data word holds DMEM_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_load_en | input | 1 | Write enable for the instruction store load port |
| imem_load_addr | input | 32 | Byte address of the instruction word being loaded |
| imem_load_data | input | 32 | Instruction word to load |
| fetch_pc | output | 32 | Address currently being fetched |
| wb_we | output | 1 | A register-file write takes effect this cycle |
| wb_dest | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value being written |
| dmem_we | output | 1 | A data-store write takes effect this cycle |
| dmem_addr | output | 32 | Full byte address of the memory-stage access |
| dmem_wdata | output | 32 | Data being stored |

## Verification
The bench builds the core with RESET_PC = 1000, RF_INIT_BASE = 100, DMEM_INIT = 99 and 64-word instruction and data stores. Starting from 1000 means fetch begins at an address that is not a multiple of the store size. Because every register starts with a different value, an operand taken from the wrong field gives a visibly wrong result. The 64-word data store is small enough that only the 32-bit dmem_addr can show whether a negative offset was sign-extended. With these values the program reaches a taken branch with its three trailing instructions, a branch that is not taken, and a store followed by a load of the same word.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN  = 32;
    localparam int RAW   = 5;
    localparam int NREGS = 1 << RAW;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'd0,
        AOP_SUB   = 2'd1,
        AOP_FUNCT = 2'd2
    } aluop_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alufn_e;

    // control group used by execute
    typedef struct packed {
        logic   imm_op;
        aluop_e alu_op;
        logic   dest_rd;
    } ex_ctl_t;

    // control group used by memory access
    typedef struct packed {
        logic rd_mem;
        logic wr_mem;
        logic branch;
    } mem_ctl_t;

    // control group used by write-back
    typedef struct packed {
        logic wr_reg;
        logic from_mem;
    } wb_ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] instr;
    } fd_reg_t;

    typedef struct packed {
        ex_ctl_t         ex;
        mem_ctl_t        mem;
        wb_ctl_t         wb;
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] a_val;
        logic [XLEN-1:0] b_val;
        logic [XLEN-1:0] imm;
        logic [RAW-1:0]  rt;
        logic [RAW-1:0]  rd;
    } dx_reg_t;

    typedef struct packed {
        mem_ctl_t        mem;
        wb_ctl_t         wb;
        logic [XLEN-1:0] target;
        logic            eq;
        logic [XLEN-1:0] alu_y;
        logic [XLEN-1:0] st_data;
        logic [RAW-1:0]  dest;
    } xm_reg_t;

    typedef struct packed {
        wb_ctl_t         wb;
        logic [XLEN-1:0] ld_data;
        logic [XLEN-1:0] alu_y;
        logic [RAW-1:0]  dest;
    } mw_reg_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        fd_reg_t         fd;
        dx_reg_t         dx;
        xm_reg_t         xm;
        mw_reg_t         mw;
    } pipe_t;

endpackage

// File: rtl/pipe5_decoder.sv
module pipe5_decoder
    import pipe5_pkg::*;
(
    input  logic [5:0] opcode,
    output ex_ctl_t    ex_o,
    output mem_ctl_t   mem_o,
    output wb_ctl_t    wb_o
);

    always_comb begin
        ex_o  = '{imm_op: 1'b0, alu_op: AOP_ADD, dest_rd: 1'b0};
        mem_o = '0;
        wb_o  = '0;
        case (opcode)
            OPC_REG: begin
                ex_o.alu_op  = AOP_FUNCT;
                ex_o.dest_rd = 1'b1;
                wb_o.wr_reg  = 1'b1;
            end
            OPC_LOAD: begin
                ex_o.imm_op   = 1'b1;
                mem_o.rd_mem  = 1'b1;
                wb_o.wr_reg   = 1'b1;
                wb_o.from_mem = 1'b1;
            end
            OPC_STORE: begin
                ex_o.imm_op  = 1'b1;
                mem_o.wr_mem = 1'b1;
            end
            OPC_BEQ: begin
                ex_o.alu_op  = AOP_SUB;
                mem_o.branch = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
(
    input  aluop_e          alu_op,
    input  logic [5:0]      funct,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    alufn_e fn;

    always_comb begin
        case (alu_op)
            AOP_ADD: fn = ALU_ADD;
            AOP_SUB: fn = ALU_SUB;
            default: begin
                case (funct)
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    default: fn = ALU_ADD;
                endcase
            end
        endcase
    end

    always_comb begin
        case (fn)
            ALU_SUB: y = op_a - op_b;
            ALU_AND: y = op_a & op_b;
            ALU_OR:  y = op_a | op_b;
            default: y = op_a + op_b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
    import pipe5_pkg::*;
#(
    parameter int unsigned INIT_BASE = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RAW-1:0]  ra_addr,
    input  logic [RAW-1:0]  rb_addr,
    output logic [XLEN-1:0] ra_val,
    output logic [XLEN-1:0] rb_val,
    input  logic            wr_en,
    input  logic [RAW-1:0]  wr_addr,
    input  logic [XLEN-1:0] wr_data
);

    logic [XLEN-1:0] regs_q [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= (i == 0) ? '0 : XLEN'(INIT_BASE + i);
            end
        end else if (wr_en && (wr_addr != '0)) begin
            regs_q[wr_addr] <= wr_data;
        end
    end

    // write-before-read: the value being written this cycle is seen by decode
    function automatic logic [XLEN-1:0] rd_port(input logic [RAW-1:0] a);
        if (a == '0)
            return '0;
        else if (wr_en && (wr_addr == a))
            return wr_data;
        else
            return regs_q[a];
    endfunction

    assign ra_val = rd_port(ra_addr);
    assign rb_val = rd_port(rb_addr);

endmodule

// File: rtl/pipe5_dmem.sv
module pipe5_dmem
    import pipe5_pkg::*;
#(
    parameter int              WORDS = 64,
    parameter logic [XLEN-1:0] INIT  = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] addr,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] rd_data
);

    localparam int AW = $clog2(WORDS);

    logic [XLEN-1:0] mem_q [WORDS];
    logic [AW-1:0]   idx;
    logic            unused_addr;

    assign idx         = addr[AW+1:2];
    assign unused_addr = ^{addr[XLEN-1:AW+2], addr[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= INIT;
            end
        end else if (wr_en) begin
            mem_q[idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[idx];

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC     = '0,
    parameter int              IMEM_WORDS   = 64,
    parameter int              DMEM_WORDS   = 64,
    parameter int unsigned     RF_INIT_BASE = 0,
    parameter logic [XLEN-1:0] DMEM_INIT    = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        imem_load_en,
    input  logic [31:0] imem_load_addr,
    input  logic [31:0] imem_load_data,
    output logic [31:0] fetch_pc,
    output logic        wb_we,
    output logic [4:0]  wb_dest,
    output logic [31:0] wb_data,
    output logic        dmem_we,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata
);

    localparam int IAW      = $clog2(IMEM_WORDS);
    localparam int IMM_W    = 16;
    localparam int IMM_PAD  = XLEN - IMM_W;

    pipe_t st_q, st_d;

    // ---------------- instruction store ----------------
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic            unused_load;

    assign unused_load = ^{imem_load_addr[XLEN-1:IAW+2], imem_load_addr[1:0]};

    always_ff @(posedge clk) begin
        if (imem_load_en) begin
            imem[imem_load_addr[IAW+1:2]] <= imem_load_data;
        end
    end

    // ---------------- fetch ----------------
    logic [XLEN-1:0] if_instr, if_pc4;
    assign if_instr = imem[st_q.pc[IAW+1:2]];
    assign if_pc4   = st_q.pc + XLEN'(4);

    // ---------------- decode ----------------
    logic [XLEN-1:0] id_instr;
    logic [RAW-1:0]  id_rs, id_rt;
    logic [XLEN-1:0] id_imm;
    logic [XLEN-1:0] rf_a, rf_b;
    ex_ctl_t         dec_ex;
    mem_ctl_t        dec_mem;
    wb_ctl_t         dec_wb;

    assign id_instr = st_q.fd.instr;
    assign id_rs    = id_instr[25:21];
    assign id_rt    = id_instr[20:16];
    assign id_imm   = {{IMM_PAD{id_instr[IMM_W-1]}}, id_instr[IMM_W-1:0]};

    pipe5_decoder u_dec (
        .opcode (id_instr[31:26]),
        .ex_o   (dec_ex),
        .mem_o  (dec_mem),
        .wb_o   (dec_wb)
    );

    // ---------------- write-back ----------------
    logic            wb_fire;
    logic [XLEN-1:0] wb_value;

    assign wb_fire  = st_q.mw.wb.wr_reg && (st_q.mw.dest != '0);
    assign wb_value = st_q.mw.wb.from_mem ? st_q.mw.ld_data : st_q.mw.alu_y;

    pipe5_regfile #(
        .INIT_BASE (RF_INIT_BASE)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (id_rs),
        .rb_addr (id_rt),
        .ra_val  (rf_a),
        .rb_val  (rf_b),
        .wr_en   (wb_fire),
        .wr_addr (st_q.mw.dest),
        .wr_data (wb_value)
    );

    // ---------------- execute ----------------
    logic [XLEN-1:0] ex_b, ex_y;
    logic            ex_zero;
    logic [RAW-1:0]  ex_dest;

    assign ex_b    = st_q.dx.ex.imm_op ? st_q.dx.imm : st_q.dx.b_val;
    assign ex_dest = st_q.dx.ex.dest_rd ? st_q.dx.rd : st_q.dx.rt;

    pipe5_alu u_alu (
        .alu_op (st_q.dx.ex.alu_op),
        .funct  (st_q.dx.imm[5:0]),
        .op_a   (st_q.dx.a_val),
        .op_b   (ex_b),
        .y      (ex_y),
        .zero   (ex_zero)
    );

    // ---------------- memory access ----------------
    logic [XLEN-1:0] mem_rdata;
    logic            mem_take;
    logic [XLEN-1:0] mem_target;
    logic [2:0]      mem_ctl_bits;

    assign mem_take     = st_q.xm.mem.branch && st_q.xm.eq;
    assign mem_target   = st_q.xm.target;
    assign mem_ctl_bits = st_q.xm.mem;

    pipe5_dmem #(
        .WORDS (DMEM_WORDS),
        .INIT  (DMEM_INIT)
    ) u_dmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (st_q.xm.alu_y),
        .wr_en   (st_q.xm.mem.wr_mem),
        .wr_data (st_q.xm.st_data),
        .rd_data (mem_rdata)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;

        st_d.pc = mem_take ? mem_target : if_pc4;

        st_d.fd.pc4   = if_pc4;
        st_d.fd.instr = if_instr;

        st_d.dx.ex    = dec_ex;
        st_d.dx.mem   = dec_mem;
        st_d.dx.wb    = dec_wb;
        st_d.dx.pc4   = st_q.fd.pc4;
        st_d.dx.a_val = rf_a;
        st_d.dx.b_val = rf_b;
        st_d.dx.imm   = id_imm;
        st_d.dx.rt    = id_rt;
        st_d.dx.rd    = id_instr[15:11];

        st_d.xm.mem     = st_q.dx.mem;
        st_d.xm.wb      = st_q.dx.wb;
        st_d.xm.target  = st_q.dx.pc4 + (st_q.dx.imm << 2);
        st_d.xm.eq      = ex_zero;
        st_d.xm.alu_y   = ex_y;
        st_d.xm.st_data = st_q.dx.b_val;
        st_d.xm.dest    = ex_dest;

        st_d.mw.wb      = st_q.xm.wb;
        st_d.mw.ld_data = mem_rdata;
        st_d.mw.alu_y   = st_q.xm.alu_y;
        st_d.mw.dest    = st_q.xm.dest;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- observation ----------------
    assign fetch_pc   = st_q.pc;
    assign wb_we      = wb_fire;
    assign wb_dest    = st_q.mw.dest;
    assign wb_data    = wb_value;
    assign dmem_we    = st_q.xm.mem.wr_mem;
    assign dmem_addr  = st_q.xm.alu_y;
    assign dmem_wdata = st_q.xm.st_data;

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
    import pipe5_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] fetch_pc,
    input logic            take,
    input logic [XLEN-1:0] target,
    input logic [RAW-1:0]  id_rs,
    input logic [XLEN-1:0] rs_val,
    input logic [RAW-1:0]  ex_dest,
    input logic [2:0]      mem_ctl,
    input logic            wb_we,
    input logic [RAW-1:0]  wb_dest
);

    logic [2:0] live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            live_q <= '0;
        else if (live_q != 3'd7)
            live_q <= live_q + 3'd1;
    end

    AST_FILL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q < 3'd4) |-> !wb_we); // R8

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((live_q != 3'd0) && !$past(take)) |-> (fetch_pc == $past(fetch_pc) + XLEN'(4))); // R2

    AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ((live_q != 3'd0) && $past(take)) |-> (fetch_pc == $past(target))); // R7

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs == '0) |-> (rs_val == '0)); // R10

    AST_MEM_CTL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_ctl)); // R3

    AST_DEST_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        ((live_q >= 3'd2) && wb_we) |-> (wb_dest == $past(ex_dest, 2))); // R4

endmodule

bind pipe5_core pipe5_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_pc (fetch_pc),
    .take     (mem_take),
    .target   (mem_target),
    .id_rs    (id_rs),
    .rs_val   (rf_a),
    .ex_dest  (ex_dest),
    .mem_ctl  (mem_ctl_bits),
    .wb_we    (wb_we),
    .wb_dest  (wb_dest)
);

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;

    localparam logic [31:0] START = 32'd1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_load_en = 1'b0;
    logic [31:0] imem_load_addr = '0;
    logic [31:0] imem_load_data = '0;
    logic [31:0] fetch_pc;
    logic        wb_we;
    logic [4:0]  wb_dest;
    logic [31:0] wb_data;
    logic        dmem_we;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;

    always #10 clk = ~clk;

    pipe5_core #(
        .RESET_PC     (START),
        .IMEM_WORDS   (64),
        .DMEM_WORDS   (64),
        .RF_INIT_BASE (100),
        .DMEM_INIT    (32'd99)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .imem_load_en   (imem_load_en),
        .imem_load_addr (imem_load_addr),
        .imem_load_data (imem_load_data),
        .fetch_pc       (fetch_pc),
        .wb_we          (wb_we),
        .wb_dest        (wb_dest),
        .wb_data        (wb_data),
        .dmem_we        (dmem_we),
        .dmem_addr      (dmem_addr),
        .dmem_wdata     (dmem_wdata)
    );

    typedef struct {
        int          cyc;
        logic [31:0] key;
        logic [31:0] data;
        string       tag;
    } item_t;

    item_t exp_wb[$];
    item_t exp_st[$];

    int  checks = 0;
    int  errors = 0;
    bit  run    = 1'b0;
    bit  done   = 1'b0;
    int  edges  = 0;

    // encoders
    function automatic logic [31:0] rform(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] iform(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d (0x%08h) expected=%0d (0x%08h)",
                     tag, what, act, act, exp, exp);
        end
    endtask

    // driver side: expected results
    task automatic push_wb(input int cyc, input int dest, input logic [31:0] data, input string tag);
        item_t it;
        it.cyc = cyc; it.key = 32'(dest); it.data = data; it.tag = tag;
        exp_wb.push_back(it);
    endtask

    task automatic push_st(input int cyc, input logic [31:0] addr, input logic [31:0] data, input string tag);
        item_t it;
        it.cyc = cyc; it.key = addr; it.data = data; it.tag = tag;
        exp_st.push_back(it);
    endtask

    task automatic load_word(input logic [31:0] addr, input logic [31:0] data);
        @(posedge clk);
        #5;
        imem_load_en   = 1'b1;
        imem_load_addr = addr;
        imem_load_data = data;
    endtask

    always @(posedge clk) begin
        if (run) edges <= edges + 1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (run && !done) begin
            automatic int c = edges + 1;
            if (c == 1) begin
                check(fetch_pc == START, "R1", "fetch_pc after reset", fetch_pc, START);
                check(wb_we == 1'b0, "R1", "wb_we after reset", 32'(wb_we), 32'd0);
                check(dmem_we == 1'b0, "R1", "dmem_we after reset", 32'(dmem_we), 32'd0);
            end
            if (c == 2)  check(fetch_pc == 32'd1004, "R2", "fetch_pc cycle 2", fetch_pc, 32'd1004);
            if (c == 14) check(fetch_pc == 32'd1052, "R2", "fetch_pc cycle 14", fetch_pc, 32'd1052);
            if (c == 15) check(fetch_pc == 32'd1060, "R7", "taken branch target", fetch_pc, 32'd1060);
            if (c == 19) check(fetch_pc == 32'd1076, "R7", "not-taken branch keeps sequence", fetch_pc, 32'd1076);

            while (exp_wb.size() > 0 && exp_wb[0].cyc < c) begin
                check(1'b0, exp_wb[0].tag, "register write missing, dest", 32'd0, exp_wb[0].key);
                void'(exp_wb.pop_front());
            end
            while (exp_st.size() > 0 && exp_st[0].cyc < c) begin
                check(1'b0, exp_st[0].tag, "store missing, addr", 32'd0, exp_st[0].key);
                void'(exp_st.pop_front());
            end

            if (wb_we) begin
                if (exp_wb.size() > 0 && exp_wb[0].cyc == c) begin
                    check(32'(wb_dest) == exp_wb[0].key, exp_wb[0].tag, "wb_dest", 32'(wb_dest), exp_wb[0].key);
                    check(wb_data == exp_wb[0].data, exp_wb[0].tag, "wb_data", wb_data, exp_wb[0].data);
                    void'(exp_wb.pop_front());
                end else begin
                    check(1'b0, "R8/R10/R11", "unexpected register write, dest", 32'(wb_dest), 32'd0);
                end
            end
            if (dmem_we) begin
                if (exp_st.size() > 0 && exp_st[0].cyc == c) begin
                    check(dmem_addr == exp_st[0].key, exp_st[0].tag, "dmem_addr", dmem_addr, exp_st[0].key);
                    check(dmem_wdata == exp_st[0].data, exp_st[0].tag, "dmem_wdata", dmem_wdata, exp_st[0].data);
                    void'(exp_st.pop_front());
                end else begin
                    check(1'b0, "R6/R11", "unexpected store, addr", dmem_addr, 32'd0);
                end
            end
        end
    end

    initial begin
        logic [31:0] prog [19];
        prog[0]  = iform(6'h23, 29, 8, 16'd4);          // lw  r8, 4(r29)
        prog[1]  = rform(4, 5, 2, 6'h22);               // sub r2, r4, r5
        prog[2]  = rform(10, 11, 9, 6'h24);             // and r9, r10, r11
        prog[3]  = rform(17, 18, 16, 6'h25);            // or  r16, r17, r18
        prog[4]  = rform(14, 0, 13, 6'h20);             // add r13, r14, r0
        prog[5]  = iform(6'h2B, 31, 9, 16'hFFFC);       // sw  r9, -4(r31)
        prog[6]  = rform(8, 8, 0, 6'h20);               // add r0, r8, r8
        prog[7]  = 32'hFC0A_5820;                       // unsupported opcode 0x3F
        prog[8]  = iform(6'h23, 31, 20, 16'hFFFC);      // lw  r20, -4(r31)
        prog[9]  = rform(0, 2, 21, 6'h20);              // add r21, r0, r2
        prog[10] = iform(6'h04, 4, 4, 16'd4);           // beq r4, r4, +4
        prog[11] = rform(4, 5, 22, 6'h25);              // or  r22, r4, r5
        prog[12] = rform(20, 21, 23, 6'h22);            // sub r23, r20, r21
        prog[13] = rform(1, 1, 24, 6'h20);              // add r24, r1, r1
        prog[14] = rform(1, 1, 25, 6'h20);              // skipped by branch
        prog[15] = iform(6'h04, 4, 5, 16'hFFF6);        // beq r4, r5 (not taken)
        prog[16] = rform(13, 16, 26, 6'h22);            // sub r26, r13, r16
        prog[17] = rform(22, 1, 27, 6'h24);             // and r27, r22, r1
        prog[18] = rform(23, 24, 28, 6'h20);            // add r28, r23, r24

        // expected retirement stream
        push_wb(5,  8,  32'd99,       "R5");   // first write-back in cycle 5 (R8), R12 data init
        push_wb(6,  2,  32'hFFFF_FFFF, "R4");
        push_wb(7,  9,  32'd110,      "R4");
        push_wb(8,  16, 32'd119,      "R4");
        push_wb(9,  13, 32'd114,      "R12");  // fifth instruction retires in cycle 9
        push_wb(13, 20, 32'd110,      "R6");   // load sees earlier store
        push_wb(14, 21, 32'hFFFF_FFFF, "R10");  // r0 source reads zero
        push_wb(16, 22, 32'd105,      "R7");   // trailing slot after taken branch
        push_wb(17, 23, 32'd111,      "R9");   // reads r21 in its write-back cycle
        push_wb(18, 24, 32'd202,      "R7");
        push_wb(20, 26, 32'hFFFF_FFFB, "R4");
        push_wb(21, 27, 32'd97,       "R4");
        push_wb(22, 28, 32'd313,      "R3");
        push_st(9, 32'd127, 32'd110,  "R6");   // data read in same cycle as r9 write (R9)

        for (int i = 0; i < 64; i++) load_word(32'(i * 4), 32'd0);
        for (int i = 0; i < 19; i++) load_word(START + 32'(i * 4), prog[i]);
        @(posedge clk);
        #5;
        imem_load_en = 1'b0;
        @(posedge clk);
        #5;
        rst_n = 1'b1;
        run   = 1'b1;

        repeat (30) @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        check(exp_wb.size() == 0, "R8", "pending register writes", 32'(exp_wb.size()), 32'd0);
        check(exp_st.size() == 0, "R6", "pending stores", 32'(exp_st.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule